// File: doc/BRIEF.md
# Streaming Protection Tuple Checker

This block checks the 8-byte protection tuple that follows each logical block in a read or write stream. A command is loaded with a single start pulse. The pulse carries the protection type, a three-bit check enable, the start address, the expected application tag and its mask, the initial reference tag, and the block count. The block validates the command before any byte arrives. After that it consumes one byte per valid cycle. For each logical block the bytes arrive as the data bytes first, then the metadata bytes. The tuple always occupies the last eight metadata bytes.

For each block the checker works out a CRC-16 guard and compares it with the stored guard. It then tests the application tag under a mask and the reference tag against a running expected value. The result is one status code with a done strobe. The checker stops at the first block that fails. Two things relax the checks. Escape tag values suppress every check on a block. A guard mismatch on an all-zero first block at address zero is forgiven.

Top module: `pi_tuple_checker`

## Requirements
- R1: Out of reset `done_o` is 0, `status_o` is 0 and `dnr_o` is 0.
- R2: At start, type 1 with the reference check enabled and `slba_i[31:0]` different from `init_ref_i` ends the command at once. `done_o` rises the cycle after `start_i`, `status_o` = 4 (invalid) and `dnr_o` = 1. No byte is consumed.
- R3: At start, type 3 with the reference check enabled ends the command the same way. `status_o` = 4 and `dnr_o` = 0.
- R4: The guard is CRC-16 with polynomial 0x8BB7, initial value 0, MSB first, no reflection and no final XOR. It is computed over the data bytes plus the metadata bytes that come before the tuple. It is stored big-endian in tuple bytes 0–1. When `chk_en_i[2]` is set, a mismatch gives status 1. When the bit is clear, the guard is ignored.
- R5: The application tag is stored big-endian in tuple bytes 2–3. When `chk_en_i[1]` is set, (stored AND mask) not equal to (expected AND mask) gives status 2.
- R6: The reference tag is stored big-endian in tuple bytes 4–7. When `chk_en_i[0]` is set, a value different from the expected tag gives status 3. For types 1 and 2 the expected tag starts at `init_ref_i` and increases by one after each block.
- R7: For types 1 and 2, a block whose application tag is 0xFFFF passes with no checks.
- R8: For type 3, a block passes with no checks only when its application tag is 0xFFFF and its reference tag is 0xFFFFFFFF.
- R9: The checks are evaluated in a fixed order: guard, then application tag, then reference tag. The first one that fails sets the status.
- R10: The command ends at the first failing block. `done_o` rises the cycle after that block's last byte. Any later bytes are ignored.
- R11: A guard mismatch is forgiven when all of the following hold: it is the first block of the command, `slba_i` is 0 and all data bytes are zero. That block then passes with no further checks.
- R12: `done_o`, `status_o` and `dnr_o` hold their values until the next `start_i`. `start_i` clears `done_o` and restarts the checker in any state.
- R13: A command covers `blk_cnt_i`+1 blocks. When every block passes, `done_o` rises the cycle after the last byte with `status_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command start pulse; loads all command fields |
| pi_type_i | input | 2 | Protection type (1, 2 or 3) |
| chk_en_i | input | 3 | Check enables: bit 2 guard, bit 1 application tag, bit 0 reference tag |
| slba_i | input | ADDR_W | Start block address |
| exp_app_i | input | 16 | Expected application tag |
| app_mask_i | input | 16 | Application tag compare mask |
| init_ref_i | input | 32 | Initial expected reference tag |
| blk_cnt_i | input | CNT_W | Number of blocks minus one |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_i | input | 8 | Stream byte |
| done_o | output | 1 | Command finished; held until next start |
| status_o | output | 3 | 0 ok, 1 guard, 2 app tag, 3 ref tag, 4 invalid |
| dnr_o | output | 1 | Do-not-retry flag for an invalid command |

## Verification
Some properties are checked by assertions on every cycle:
- the result outputs stay frozen while `done_o` is held;
- the do-not-retry flag never appears with any status except invalid;
- a type 3 reference-check request is rejected on the next cycle;
- the guard register stays still while tuple bytes stream in.

Other behaviour only the bench scenarios can show. This covers:
- the CRC coverage of the pre-tuple metadata;
- the masked tag compare;
- the reference increment across blocks;
- the escape rules for each type;
- the check priority;
- the first-block zero forgiveness, which must not extend to later blocks or non-zero addresses.

The bench's behavioural model predicts the exact done cycle for each command, so a late or early stop is seen.

// File: rtl/pi_chk_pkg.sv
package pi_chk_pkg;
  localparam int TUPLE_BYTES = 8;
  localparam int GUARD_W = 16;
  localparam int APP_W = 16;
  localparam int REF_W = 32;
  localparam int CHK_GUARD = 2;
  localparam int CHK_APP = 1;
  localparam int CHK_REF = 0;
  localparam logic [GUARD_W-1:0] GUARD_POLY = 16'h8BB7;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_GUARD   = 3'd1,
    ST_APP     = 3'd2,
    ST_REF     = 3'd3,
    ST_INVALID = 3'd4
  } pi_status_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_DONE = 2'd2
  } chk_state_e;
endpackage

// File: rtl/pi_crc_step.sv
module pi_crc_step #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = 16'h8BB7
) (
  input  logic [W-1:0] crc_i,
  input  logic [7:0]   byte_i,
  output logic [W-1:0] crc_o
);
  always_comb begin
    logic [W-1:0] c;
    c = crc_i;
    for (int k = 7; k >= 0; k--) begin
      if (c[W-1] ^ byte_i[k]) c = {c[W-2:0], 1'b0} ^ POLY;
      else                    c = {c[W-2:0], 1'b0};
    end
    crc_o = c;
  end
endmodule

// File: rtl/pi_cmd_validate.sv
module pi_cmd_validate
  import pi_chk_pkg::*;
(
  input  logic [1:0]       typ_i,
  input  logic [2:0]       chk_i,
  input  logic [REF_W-1:0] slba_lo_i,
  input  logic [REF_W-1:0] ref_i,
  output logic             reject_o,
  output logic             dnr_o
);
  logic t1_bad, t3_bad;
  assign t1_bad   = (typ_i == 2'd1) && chk_i[CHK_REF] && (slba_lo_i != ref_i);
  assign t3_bad   = (typ_i == 2'd3) && chk_i[CHK_REF];
  assign reject_o = t1_bad || t3_bad;
  assign dnr_o    = t1_bad;
endmodule

// File: rtl/pi_tuple_eval.sv
module pi_tuple_eval
  import pi_chk_pkg::*;
(
  input  logic [1:0]                 typ_i,
  input  logic [2:0]                 chk_i,
  input  logic [APP_W-1:0]           exp_app_i,
  input  logic [APP_W-1:0]           app_mask_i,
  input  logic [REF_W-1:0]           exp_ref_i,
  input  logic [GUARD_W-1:0]         calc_guard_i,
  input  logic [TUPLE_BYTES*8-1:0]   tuple_i,
  input  logic                       forgive_ok_i,
  output pi_status_e                 status_o
);
  logic [GUARD_W-1:0] st_guard;
  logic [APP_W-1:0]   st_app;
  logic [REF_W-1:0]   st_ref;
  logic               esc;

  assign st_guard = tuple_i[63:48];
  assign st_app   = tuple_i[47:32];
  assign st_ref   = tuple_i[31:0];

  assign esc = ((typ_i == 2'd1 || typ_i == 2'd2) && (st_app == '1)) ||
               ((typ_i == 2'd3) && (st_app == '1) && (st_ref == '1));

  always_comb begin
    status_o = ST_OK;
    if (!esc) begin
      if (chk_i[CHK_GUARD] && st_guard != calc_guard_i) begin
        if (!forgive_ok_i) status_o = ST_GUARD;
      end else if (chk_i[CHK_APP] && ((st_app & app_mask_i) != (exp_app_i & app_mask_i))) begin
        status_o = ST_APP;
      end else if (chk_i[CHK_REF] && st_ref != exp_ref_i) begin
        status_o = ST_REF;
      end
    end
  end
endmodule

// File: rtl/pi_tuple_checker.sv
module pi_tuple_checker
  import pi_chk_pkg::*;
#(
  parameter int BLK_BYTES = 16,
  parameter int MD_BYTES  = 10,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        pi_type_i,
  input  logic [2:0]        chk_en_i,
  input  logic [ADDR_W-1:0] slba_i,
  input  logic [15:0]       exp_app_i,
  input  logic [15:0]       app_mask_i,
  input  logic [31:0]       init_ref_i,
  input  logic [CNT_W-1:0]  blk_cnt_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              done_o,
  output logic [2:0]        status_o,
  output logic              dnr_o
);
  localparam int BB   = BLK_BYTES + MD_BYTES;
  localparam int PRE  = BB - TUPLE_BYTES;
  localparam int BC_W = $clog2(BB);
  localparam logic [BC_W-1:0] PRE_C  = BC_W'(PRE);
  localparam logic [BC_W-1:0] DATA_C = BC_W'(BLK_BYTES);
  localparam logic [BC_W-1:0] LAST_C = BC_W'(BB - 1);

  chk_state_e          state_q;
  logic [1:0]          typ_q;
  logic [2:0]          chk_q;
  logic [APP_W-1:0]    app_q, mask_q;
  logic [REF_W-1:0]    ref_q;
  logic                zero_addr_q, zero_q, first_q;
  logic [CNT_W-1:0]    blk_q, last_blk_q;
  logic [BC_W-1:0]     byte_cnt_q;
  logic [GUARD_W-1:0]  crc_q, crc_nxt;
  logic [TUPLE_BYTES*8-9:0] tup_q;
  logic                done_q, dnr_q;
  pi_status_e          status_q, ev_status;
  logic                reject, rej_dnr, blk_end, take;

  pi_cmd_validate u_validate (
    .typ_i(pi_type_i), .chk_i(chk_en_i),
    .slba_lo_i(slba_i[REF_W-1:0]), .ref_i(init_ref_i),
    .reject_o(reject), .dnr_o(rej_dnr)
  );

  pi_crc_step #(.W(GUARD_W), .POLY(GUARD_POLY)) u_crc (
    .crc_i(crc_q), .byte_i(byte_i), .crc_o(crc_nxt)
  );

  pi_tuple_eval u_eval (
    .typ_i(typ_q), .chk_i(chk_q), .exp_app_i(app_q), .app_mask_i(mask_q),
    .exp_ref_i(ref_q), .calc_guard_i(crc_q), .tuple_i({tup_q, byte_i}),
    .forgive_ok_i(first_q && zero_addr_q && zero_q), .status_o(ev_status)
  );

  assign take    = (state_q == S_RUN) && byte_valid_i;
  assign blk_end = take && (byte_cnt_q == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      typ_q       <= '0;
      chk_q       <= '0;
      app_q       <= '0;
      mask_q      <= '0;
      ref_q       <= '0;
      zero_addr_q <= 1'b0;
      zero_q      <= 1'b1;
      first_q     <= 1'b1;
      blk_q       <= '0;
      last_blk_q  <= '0;
      byte_cnt_q  <= '0;
      crc_q       <= '0;
      tup_q       <= '0;
      done_q      <= 1'b0;
      dnr_q       <= 1'b0;
      status_q    <= ST_OK;
    end else if (start_i) begin
      typ_q       <= pi_type_i;
      chk_q       <= chk_en_i;
      app_q       <= exp_app_i;
      mask_q      <= app_mask_i;
      ref_q       <= init_ref_i;
      zero_addr_q <= (slba_i == '0);
      zero_q      <= 1'b1;
      first_q     <= 1'b1;
      blk_q       <= '0;
      last_blk_q  <= blk_cnt_i;
      byte_cnt_q  <= '0;
      crc_q       <= '0;
      tup_q       <= '0;
      if (reject) begin
        state_q  <= S_DONE;
        done_q   <= 1'b1;
        status_q <= ST_INVALID;
        dnr_q    <= rej_dnr;
      end else begin
        state_q  <= S_RUN;
        done_q   <= 1'b0;
        status_q <= ST_OK;
        dnr_q    <= 1'b0;
      end
    end else if (take) begin
      if (byte_cnt_q < PRE_C) crc_q <= crc_nxt;
      if (byte_cnt_q < DATA_C && byte_i != 8'h00) zero_q <= 1'b0;
      tup_q <= {tup_q[TUPLE_BYTES*8-17:0], byte_i};
      if (blk_end) begin
        if (ev_status != ST_OK) begin
          state_q  <= S_DONE;
          done_q   <= 1'b1;
          status_q <= ev_status;
        end else if (blk_q == last_blk_q) begin
          state_q  <= S_DONE;
          done_q   <= 1'b1;
          status_q <= ST_OK;
        end else begin
          blk_q      <= blk_q + 1'b1;
          byte_cnt_q <= '0;
          crc_q      <= '0;
          zero_q     <= 1'b1;
          first_q    <= 1'b0;
          if (typ_q != 2'd3) ref_q <= ref_q + 1'b1;
        end
      end else begin
        byte_cnt_q <= byte_cnt_q + 1'b1;
      end
    end
  end

  assign done_o   = done_q;
  assign status_o = status_q;
  assign dnr_o    = dnr_q;

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !start_i |=> done_q && $stable(status_q) && $stable(dnr_q)); // R12
  AST_DNR_ONLY_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dnr_q |-> status_q == ST_INVALID); // R2
  AST_T3_REF_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && pi_type_i == 2'd3 && chk_en_i[CHK_REF]
      |=> done_q && status_q == ST_INVALID && !dnr_q); // R3
  AST_GUARD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !start_i && byte_cnt_q >= PRE_C && !blk_end |=> $stable(crc_q)); // R4
  AST_BYTE_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_RUN |-> byte_cnt_q <= LAST_C); // R10
endmodule

// File: tb/pi_tuple_checker_tb_top.sv
module pi_tuple_checker_tb_top;
  localparam int BLK = 16;
  localparam int MD  = 10;
  localparam int BB  = BLK + MD;
  localparam int PRE = BB - 8;
  localparam int CW  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, bvalid = 1'b0;
  logic [1:0] ptype = '0;
  logic [2:0] chk = '0;
  logic [63:0] slba = '0;
  logic [15:0] eapp = '0, amask = '0;
  logic [31:0] iref = '0;
  logic [CW-1:0] nblk = '0;
  logic [7:0] bdat = '0;
  logic done;
  logic [2:0] status;
  logic dnr;

  int checks = 0, fails = 0;
  bit [7:0] stream[$];

  always #4 clk = ~clk;

  pi_tuple_checker #(.BLK_BYTES(BLK), .MD_BYTES(MD), .CNT_W(CW), .ADDR_W(64)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pi_type_i(ptype), .chk_en_i(chk),
    .slba_i(slba), .exp_app_i(eapp), .app_mask_i(amask), .init_ref_i(iref),
    .blk_cnt_i(nblk), .byte_valid_i(bvalid), .byte_i(bdat),
    .done_o(done), .status_o(status), .dnr_o(dnr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit [15:0] crc_b(input bit [15:0] c, input bit [7:0] d);
    bit [15:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      bit fb = r[15] ^ d[k];
      r = r << 1;
      if (fb) r = r ^ 16'h8BB7;
    end
    return r;
  endfunction

  task automatic add_block(input int seed, input bit zero, input bit [15:0] app,
                           input bit [31:0] rf, input bit bad_guard);
    bit [15:0] c = 16'h0;
    for (int i = 0; i < PRE; i++) begin
      bit [7:0] b;
      b = (zero && i < BLK) ? 8'h00 : 8'((seed * 37 + i * 11 + 1) | 1);
      c = crc_b(c, b);
      stream.push_back(b);
    end
    if (bad_guard) c = c ^ 16'h5A5A;
    stream.push_back(c[15:8]);  stream.push_back(c[7:0]);
    stream.push_back(app[15:8]); stream.push_back(app[7:0]);
    stream.push_back(rf[31:24]); stream.push_back(rf[23:16]);
    stream.push_back(rf[15:8]);  stream.push_back(rf[7:0]);
  endtask

  // behavioural reference: status, dnr flag and cycles from start to done
  task automatic model(output int st, output bit mdnr, output int lat);
    bit [31:0] r = iref;
    mdnr = 0;
    if (ptype == 2'd1 && chk[0] && slba[31:0] != iref) begin st = 4; mdnr = 1; lat = 0; return; end
    if (ptype == 2'd3 && chk[0]) begin st = 4; lat = 0; return; end
    for (int b = 0; b <= int'(nblk); b++) begin
      int base = b * BB;
      bit [15:0] c = 0, g, a;
      bit [31:0] t;
      bit allz = 1, esc;
      int s = 0;
      for (int i = 0; i < PRE; i++) begin
        c = crc_b(c, stream[base + i]);
        if (i < BLK && stream[base + i] != 0) allz = 0;
      end
      g = {stream[base + PRE], stream[base + PRE + 1]};
      a = {stream[base + PRE + 2], stream[base + PRE + 3]};
      t = {stream[base + PRE + 4], stream[base + PRE + 5], stream[base + PRE + 6], stream[base + PRE + 7]};
      esc = (ptype == 3) ? (a == 16'hFFFF && t == 32'hFFFFFFFF)
                         : ((ptype == 1 || ptype == 2) && a == 16'hFFFF);
      if (!esc) begin
        if (chk[2] && g != c) begin
          if (!(b == 0 && slba == 0 && allz)) s = 1;
        end else if (chk[1] && (a & amask) != (eapp & amask)) s = 2;
        else if (chk[0] && t != r) s = 3;
      end
      if (s != 0) begin st = s; lat = (b + 1) * BB; return; end
      if (ptype != 3) r++;
    end
    st = 0;
    lat = (int'(nblk) + 1) * BB;
  endtask

  task automatic run_cmd(input string req, input bit [1:0] t, input bit [2:0] c,
                         input bit [63:0] sa, input bit [15:0] ap, input bit [15:0] mk,
                         input bit [31:0] rf, input int nb);
    int est, elat;
    bit edn;
    @(negedge clk);
    ptype = t; chk = c; slba = sa; eapp = ap; amask = mk; iref = rf; nblk = CW'(nb);
    start = 1'b1;
    model(est, edn, elat);
    @(posedge clk);
    for (int n = 0; n <= stream.size() + 2; n++) begin
      @(negedge clk);
      start = 1'b0;
      check(done === (n >= elat), req, "done", done, n >= elat);
      if (n >= elat) begin
        check(status === 3'(est), req, "status", status, est);
        check(dnr === edn, req, "dnr", dnr, edn);
      end
      bvalid = (n < stream.size());
      bdat   = (n < stream.size()) ? stream[n] : 8'h00;
    end
    bvalid = 1'b0;
    stream.delete();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done === 1'b0, "R1", "done", done, 0);
    check(status === 3'd0, "R1", "status", status, 0);
    check(dnr === 1'b0, "R1", "dnr", dnr, 0);

    // R13 R6: three clean type-1 blocks with incrementing reference
    add_block(1, 0, 16'h1234, 100, 0); add_block(2, 0, 16'h1234, 101, 0); add_block(3, 0, 16'h1234, 102, 0);
    run_cmd("R13", 1, 3'b111, 100, 16'h1234, 16'hFFFF, 100, 2);
    // R2: address/reference mismatch rejected with do-not-retry
    add_block(1, 0, 16'h1234, 100, 0);
    run_cmd("R2", 1, 3'b111, 101, 16'h1234, 16'hFFFF, 100, 0);
    // R2: no reference check, no rejection
    add_block(4, 0, 16'h0, 7, 0);
    run_cmd("R2", 1, 3'b110, 55, 16'h0, 16'hFFFF, 7, 0);
    // R3: type 3 reference check rejected
    add_block(1, 0, 16'h1, 5, 0);
    run_cmd("R3", 3, 3'b101, 5, 16'h1, 16'hFFFF, 5, 0);
    // R4 R10: guard error in block 1 of 3, later bytes ignored
    add_block(5, 0, 16'h1, 9, 0); add_block(6, 0, 16'h1, 10, 1); add_block(7, 0, 16'h1, 11, 0);
    run_cmd("R10", 2, 3'b111, 3, 16'h1, 16'hFFFF, 9, 2);
    // R4: guard bad but guard check disabled
    add_block(8, 0, 16'h1, 9, 1);
    run_cmd("R4", 2, 3'b011, 3, 16'h1, 16'hFFFF, 9, 0);
    // R5: differing in masked-out bits only, then in a masked bit
    add_block(9, 0, 16'hAB0F, 20, 0);
    run_cmd("R5", 2, 3'b111, 1, 16'hAB00, 16'hFFF0, 20, 0);
    add_block(9, 0, 16'hAB0F, 20, 0);
    run_cmd("R5", 2, 3'b111, 1, 16'hAA0F, 16'hFFF0, 20, 0);
    // R6: wrong reference in third block
    add_block(10, 0, 16'h2, 40, 0); add_block(11, 0, 16'h2, 41, 0); add_block(12, 0, 16'h2, 43, 0);
    run_cmd("R6", 1, 3'b111, 40, 16'h2, 16'hFFFF, 40, 2);
    // R7: escape application tag with bad guard
    add_block(13, 0, 16'hFFFF, 0, 1);
    run_cmd("R7", 1, 3'b111, 60, 16'h3, 16'hFFFF, 60, 0);
    // R8: type 3 needs both escapes
    add_block(14, 0, 16'hFFFF, 32'h1, 1);
    run_cmd("R8", 3, 3'b110, 8, 16'h3, 16'hFFFF, 0, 0);
    add_block(14, 0, 16'hFFFF, 32'hFFFFFFFF, 1);
    run_cmd("R8", 3, 3'b110, 8, 16'h3, 16'hFFFF, 0, 0);
    // R9: priority guard > app > ref
    add_block(15, 0, 16'h9, 1, 1);
    run_cmd("R9", 2, 3'b111, 0, 16'h3, 16'hFFFF, 70, 0);
    add_block(15, 0, 16'h9, 1, 0);
    run_cmd("R9", 2, 3'b111, 0, 16'h3, 16'hFFFF, 70, 0);
    // R11: forgiveness only on zero first block at address zero
    add_block(0, 1, 16'h4, 0, 1); add_block(16, 0, 16'h4, 1, 0);
    run_cmd("R11", 1, 3'b111, 0, 16'h4, 16'hFFFF, 0, 1);
    add_block(0, 1, 16'h4, 5, 1);
    run_cmd("R11", 1, 3'b111, 5, 16'h4, 16'hFFFF, 5, 0);
    add_block(17, 0, 16'h4, 0, 0); add_block(0, 1, 16'h4, 1, 1);
    run_cmd("R11", 1, 3'b111, 0, 16'h4, 16'hFFFF, 0, 1);
    // R12: done/status hold while idle, then restart clears
    repeat (5) begin
      @(negedge clk);
      check(done === 1'b1 && status === 3'd1, "R12", "hold", {done, status}, 4'h9);
    end
    add_block(18, 0, 16'h5, 9, 0);
    run_cmd("R12", 2, 3'b111, 2, 16'h5, 16'hFFFF, 9, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule